// File: doc/BRIEF.md
# Checkpointed Shadow Register File

This block is a register file with two read ports and one write port in which every register is held twice. One copy is live and the other is saved. Reads and writes act only on the live copies. A one-cycle commit pulse copies the whole live set into the saved set, which marks a checkpoint. A one-cycle rollback pulse copies the saved set back over the live set, which discards all work since that checkpoint.

A pipeline that runs ahead speculatively writes freely into the file. It commits when a region turns out to be valid and rolls back when one of its assumptions fails. Commit costs no cycles: a write may be issued on the commit cycle itself and again on the cycle after it.

Top module: `ckpt_shadow_rf`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets every live and every saved register to zero, so reads return zero and a rollback straight after reset also leaves zero everywhere.
- R2: When wr_en is high at a rising edge, wr_data is written into the live copy of register wr_addr. From the next cycle on, both read ports return that value for that address.
- R3: A write without a commit never changes a saved copy. A later rollback returns the value that was committed before the write.
- R4: A commit (commit=1, rollback=0) copies every live register into its saved copy at one edge. The port accepts a write on the very next cycle, and that write does not touch the checkpoint.
- R5: A rollback copies every saved register into its live copy at one edge. Reads in the next cycle return the restored values.
- R6: When commit and rollback are both high, the rollback takes effect and the saved copies stay unchanged.
- R7: A write issued on the same edge as a commit is part of the committed state.
- R8: A write issued on the same edge as a rollback is discarded. The register takes its saved value.
- R9: When wr_en is high and a read address equals wr_addr, that read port returns wr_data in the same cycle. This holds even when the write is later discarded by a rollback.
- R10: The two read ports are independent. Each returns the live value of its own address in the same cycle, with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr_a | input | AW | Read port A address |
| rd_data_a | output | DW | Read port A data (live copy, bypassed) |
| rd_addr_b | input | AW | Read port B address |
| rd_data_b | output | DW | Read port B data (live copy, bypassed) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| commit | input | 1 | Checkpoint pulse: live set to saved set |
| rollback | input | 1 | Restore pulse: saved set to live set; wins over commit |

## Verification
The assertions check the following on every cycle:
- After a commit, the whole saved set equals the whole live set.
- Without a commit, the saved set does not move.
- After a rollback, the live set equals the saved set from the cycle before.
- When both pulses arrive together, the result is exactly a rollback.
- Both read ports show the write data on an address match.

Only the bench's scenarios can show the rest:
- Reset leaves zero in the saved copies.
- A write on the commit edge lands in the checkpoint.
- A write on the rollback edge is lost.
- The port takes a write on the cycle right after a commit.

The bench shows these by comparing read-back values against a model of both copies across a long random mix of operations.

// File: rtl/ckpt_rf_pkg.sv
package ckpt_rf_pkg;

  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_COMMIT  = 2'd1,
    OP_RESTORE = 2'd2
  } ckpt_op_e;

  // Restore outranks checkpoint when both pulses coincide.
  function automatic ckpt_op_e resolve_op(input logic take_ckpt, input logic restore);
    if (restore)        return OP_RESTORE;
    else if (take_ckpt) return OP_COMMIT;
    else                return OP_HOLD;
  endfunction

endpackage

// File: rtl/ckpt_rf_ctrl.sv
module ckpt_rf_ctrl
  import ckpt_rf_pkg::*;
(
  input  logic commit,
  input  logic rollback,
  output logic commit_fire,
  output logic restore_fire
);

  ckpt_op_e op;

  always_comb begin
    op           = resolve_op(commit, rollback);
    commit_fire  = (op == OP_COMMIT);
    restore_fire = (op == OP_RESTORE);
  end

endmodule

// File: rtl/ckpt_rf_cell.sv
module ckpt_rf_cell #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          commit_fire,
  input  logic          restore_fire,
  output logic [DW-1:0] work_q,
  output logic [DW-1:0] shad_q
);

  logic [DW-1:0] work_next;

  assign work_next = wr_hit ? wr_data : work_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      shad_q <= '0;
    end else if (restore_fire) begin
      work_q <= shad_q;
    end else begin
      work_q <= work_next;
      if (commit_fire) shad_q <= work_next;
    end
  end

endmodule

// File: rtl/ckpt_rf_rdport.sv
module ckpt_rf_rdport #(
  parameter int NREGS = 8,
  parameter int DW    = 16,
  parameter int AW    = 3
) (
  input  logic [NREGS*DW-1:0] work_flat,
  input  logic [AW-1:0]       rd_addr,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  output logic                bypass_hit,
  output logic [DW-1:0]       rd_data
);

  logic [DW-1:0] stored;

  always_comb begin
    stored = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_addr == AW'(i)) stored = work_flat[i*DW +: DW];
    end
  end

  assign bypass_hit = wr_en && (wr_addr == rd_addr);
  assign rd_data    = bypass_hit ? wr_data : stored;

endmodule

// File: rtl/ckpt_shadow_rf.sv
module ckpt_shadow_rf #(
  parameter int NREGS = 8,
  parameter int DW    = 16,
  parameter int AW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rollback
);

  localparam int FLATW = NREGS * DW;

  logic             commit_fire;
  logic             restore_fire;
  logic [NREGS-1:0] wr_hit;
  logic [FLATW-1:0] work_flat;
  logic [FLATW-1:0] shad_flat;
  logic             bypass_a;
  logic             bypass_b;

  ckpt_rf_ctrl u_ctrl (
    .commit       (commit),
    .rollback     (rollback),
    .commit_fire  (commit_fire),
    .restore_fire (restore_fire)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    assign wr_hit[g] = wr_en && (wr_addr == AW'(g));

    ckpt_rf_cell #(.DW(DW)) u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_hit       (wr_hit[g]),
      .wr_data      (wr_data),
      .commit_fire  (commit_fire),
      .restore_fire (restore_fire),
      .work_q       (work_flat[g*DW +: DW]),
      .shad_q       (shad_flat[g*DW +: DW])
    );
  end

  ckpt_rf_rdport #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_rd_a (
    .work_flat  (work_flat),
    .rd_addr    (rd_addr_a),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .bypass_hit (bypass_a),
    .rd_data    (rd_data_a)
  );

  ckpt_rf_rdport #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_rd_b (
    .work_flat  (work_flat),
    .rd_addr    (rd_addr_b),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .bypass_hit (bypass_b),
    .rd_data    (rd_data_b)
  );

endmodule

// File: rtl/ckpt_shadow_rf_chk.sv
module ckpt_shadow_rf_chk #(
  parameter int NREGS = 8,
  parameter int DW    = 16,
  parameter int AW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                commit,
  input logic                rollback,
  input logic                commit_fire,
  input logic                restore_fire,
  input logic [NREGS*DW-1:0] work_flat,
  input logic [NREGS*DW-1:0] shad_flat,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic [DW-1:0]       wr_data,
  input logic [AW-1:0]       rd_addr_a,
  input logic [DW-1:0]       rd_data_a,
  input logic [AW-1:0]       rd_addr_b,
  input logic [DW-1:0]       rd_data_b
);

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(shad_flat));

  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (shad_flat == work_flat));

  assert_restore_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_fire |=> (work_flat == $past(shad_flat)));

  assert_restore_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rollback) |=> ($stable(shad_flat) && work_flat == $past(shad_flat)));

  assert_bypass_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr_a) |-> (rd_data_a == wr_data));

  assert_bypass_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr_b) |-> (rd_data_b == wr_data));

endmodule

bind ckpt_shadow_rf ckpt_shadow_rf_chk #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit       (commit),
  .rollback     (rollback),
  .commit_fire  (commit_fire),
  .restore_fire (restore_fire),
  .work_flat    (work_flat),
  .shad_flat    (shad_flat),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .rd_addr_a    (rd_addr_a),
  .rd_data_a    (rd_data_a),
  .rd_addr_b    (rd_addr_b),
  .rd_data_b    (rd_data_b)
);

// File: tb/ckpt_shadow_rf_test.sv
module ckpt_shadow_rf_test;

  localparam int PERIOD = 10;
  localparam int NREGS  = 8;
  localparam int DW     = 16;
  localparam int AW     = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data = '0;
  logic          wr_en = 1'b0, commit = 1'b0, rollback = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] exp_work [NREGS];
  logic [DW-1:0] exp_shad [NREGS];
  logic [31:0]   lfsr = 32'h1ACE_5EED;

  always #(PERIOD/2) clk = ~clk;

  ckpt_shadow_rf #(.NREGS(NREGS), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .rollback(rollback)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int seed, input int idx);
    return DW'(seed * 16'h0F1D + idx * 16'h0125 + 16'h3C00);
  endfunction

  // One cycle: drive at the falling edge, check reads, then advance the model.
  task automatic step(input string tag, input logic we, input int wa, input logic [DW-1:0] wd,
                      input logic cm, input logic rb, input int ra, input int rbb);
    logic [DW-1:0] ea, eb;
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    commit = cm; rollback = rb;
    rd_addr_a = AW'(ra); rd_addr_b = AW'(rbb);
    #1;
    ea = (we && wa == ra)  ? wd : exp_work[ra];
    eb = (we && wa == rbb) ? wd : exp_work[rbb];
    check(tag, rd_data_a, ea);
    check(tag, rd_data_b, eb);
    @(posedge clk);
    if (rb) begin
      for (int i = 0; i < NREGS; i++) exp_work[i] = exp_shad[i];
    end else begin
      if (we) exp_work[wa] = wd;
      if (cm) for (int i = 0; i < NREGS; i++) exp_shad[i] = exp_work[i];
    end
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NREGS; i++) step(tag, 1'b0, 0, '0, 1'b0, 1'b0, i, NREGS-1-i);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < NREGS; i++) begin exp_work[i] = '0; exp_shad[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, and rollback right after reset keeps zero
    sweep("R1");
    step("R1", 1'b0, 0, '0, 1'b0, 1'b1, 0, 1);
    sweep("R1");

    // R2, R9, R10: write all registers, read with bypass and afterwards
    for (int i = 0; i < NREGS; i++) step("R9", 1'b1, i, pattern(1, i), 1'b0, 1'b0, i, (i+3) % NREGS);
    sweep("R2");

    // R3, R5: uncommitted writes are undone by rollback
    step("R5", 1'b0, 0, '0, 1'b0, 1'b1, 2, 5);
    sweep("R3");

    // R4, R7: rewrite, commit together with last write, write on next cycle
    for (int i = 0; i < NREGS-1; i++) step("R2", 1'b1, i, pattern(2, i), 1'b0, 1'b0, i, 0);
    step("R7", 1'b1, NREGS-1, pattern(2, NREGS-1), 1'b1, 1'b0, NREGS-1, 0);
    step("R4", 1'b1, 0, 16'hDEAD, 1'b0, 1'b0, 0, NREGS-1);
    step("R4", 1'b1, 1, 16'hBEEF, 1'b0, 1'b0, 0, 1);
    step("R5", 1'b0, 0, '0, 1'b0, 1'b1, 0, 1);
    sweep("R7");

    // R8: write during rollback is discarded
    step("R8", 1'b1, 3, 16'h5A5A, 1'b0, 1'b1, 3, 4);
    sweep("R8");

    // R6: both pulses together act as rollback only
    for (int i = 0; i < NREGS; i++) step("R2", 1'b1, i, pattern(3, i), 1'b0, 1'b0, i, i);
    step("R6", 1'b1, 6, 16'h0BAD, 1'b1, 1'b1, 6, 7);
    sweep("R6");
    step("R6", 1'b0, 0, '0, 1'b0, 1'b1, 0, 0);
    sweep("R6");

    // Mixed random traffic against the two-copy model
    for (int n = 0; n < 400; n++) begin
      logic we, cm, rb;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      we = (lfsr[1:0] != 2'b00);
      cm = (lfsr[4:2] == 3'b000);
      rb = (lfsr[7:5] == 3'b000);
      step("R10", we, int'(lfsr[10:8]), lfsr[31:16], cm, rb, int'(lfsr[13:11]), int'(lfsr[15:14]) * 2);
      if (n % 50 == 49) sweep("R3");
    end
    step("R5", 1'b0, 0, '0, 1'b0, 1'b1, 0, 0);
    sweep("R5");

    report();
  end

endmodule